// File: doc/BRIEF.md
# Vector Condition-Field Logic Sequencer

The block runs one two-input bit operation across a vector of 4-bit condition fields, one element per clock. Each field has four flags: less-than (bit 0), greater-than (bit 1), equal (bit 2) and summary-overflow (bit 3). The fields live in a 128-entry register file inside the block. Fields 0-7 are meant for scalar use and 8-127 for vectors. A 2-bit selector names one flag within a field, with value s meaning field bit s. The operation comes from a 4-entry truth table `op_lut`. The result for source bits a and b is `op_lut[2*a+b]`, so AND is 4'b1000, OR is 4'b1110, XOR is 4'b0110 and NOR is 4'b0001.

A start pulse captures the operand bases, the mode word, the predicate mask and the vector length. The block then visits the elements in ascending or descending order. For element i, a vector operand uses field base+i (modulo 128) and a scalar operand uses its base. The block writes each result back before it reads the next element, so operands that overlap the destination chain from one element to the next. In the data-dependent early-exit modes, the block tests one flag of each result and stops at the first failing element. It then reports a shortened vector length. A one-cycle done pulse carries the final length. A host port loads and reads fields while the block is idle.

The 7-bit mode word is laid out as {zz[6], snz[5], sel[4:3], rgi[2], lo[1:0]}. The sel field picks the mode: 00 is plain, 10 is reduce, 01 is early exit that excludes the failing element, and 11 is early exit that includes it. In plain and reduce modes, rgi is reverse order, lo[1] zeroes the destination and lo[0] zeroes the source. In early-exit modes, rgi inverts the test and the order is always ascending.

Top module: `cr_vec_seq`

## Requirements
- R1: After reset, busy, done and vl_out are all 0.
- R2: In plain mode with rgi=0, element i goes in ascending order. Its destination bit t_sel of field t_base+i becomes op_lut[2*a+b]. Here a is bit a_sel of the A field and b is bit b_sel of the B field. The other three destination bits keep their values.
- R3: With field_wide=1, all four destination bits are written. Bit k of the destination is op_lut[2*A[k]+B[k]].
- R4: With rgi=1 in plain or reduce mode, elements go from VL-1 down to 0. Each write is visible to the next element, so a destination that overlaps a source offset by one field accumulates down the chain.
- R5: An element whose predicate bit is 0 is skipped when lo[1]=0. When lo[1]=1, a zero is written instead: the single destination bit in narrow mode, or the whole field in wide mode.
- R6: In reduce mode (sel=10), the destination field stays at t_base for every element. Source addresses still advance when their vector flag is 1.
- R7: In early-exit mode in narrow form, the tested flag is the destination bit the element has just written. The test fails when that bit equals rgi. With sel=11, the failing element is written and vl_out = index+1.
- R8: With sel=01, the failing element is not written and vl_out = index. Later elements are never processed.
- R9: In early-exit mode in wide form, lo selects the tested bit of the result field. zz supplies both the source-zero and destination-zero flags.
- R10: In early-exit mode, an element whose predicate bit is 0 is tested as if its flag were snz when source zeroing is on. When source zeroing is off, the element is not tested.
- R11: done pulses for exactly one cycle, N cycles after the start edge, where N is the number of elements processed (0 for VL=0). vl_in above MAXVL counts as MAXVL. With no failure, vl_out equals that length, and it never exceeds it.
- R12: When the sequencer is not writing, a host write stores host_wdata into field host_waddr. host_rdata always shows field host_raddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| mode_word | input | 7 | {zz, snz, sel[1:0], rgi, lo[1:0]} |
| op_lut | input | 4 | Truth table indexed by {a,b} |
| field_wide | input | 1 | 1: whole-field operation, 0: single-bit operation |
| a_is_vec | input | 1 | A base advances with the element index |
| b_is_vec | input | 1 | B base advances with the element index |
| a_base | input | 7 | A field base |
| a_sel | input | 2 | A bit selector |
| b_base | input | 7 | B field base |
| b_sel | input | 2 | B bit selector |
| t_base | input | 7 | Destination field base |
| t_sel | input | 2 | Destination bit selector |
| pred_mask | input | 64 | Predicate bit per element index |
| vl_in | input | 7 | Requested vector length |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end pulse |
| vl_out | output | 7 | Final (possibly shortened) length |
| host_we | input | 1 | Host field write |
| host_waddr | input | 7 | Host write field |
| host_wdata | input | 4 | Host write value |
| host_raddr | input | 7 | Host read field |
| host_rdata | output | 4 | Host read value |

## Verification
The stepping and pulse properties assume two things. First, start is only raised while the block is idle. Second, the host port is used only between sequences. The bench keeps to both by loading every field, pulsing start once and waiting for done before it touches the host port again. The write-gating properties assume the captured mode is stable for a whole run, and the capture registers guarantee this. The sweeps cover four truth tables, every mode and a range of vector lengths. These include a length above the maximum and a length of zero, and pseudo-random field contents and predicate masks.

// File: rtl/cr_seq_pkg.sv
package cr_seq_pkg;
  localparam int FW = 4;

  typedef struct packed {
    logic       zz;
    logic       snz;
    logic [1:0] sel;
    logic       rgi;
    logic [1:0] lo;
  } mode_t;

  localparam logic [1:0] SEL_PLAIN  = 2'b00;
  localparam logic [1:0] SEL_REDUCE = 2'b10;
endpackage

// File: rtl/cr_field_file.sv
module cr_field_file
  import cr_seq_pkg::*;
#(
  parameter int NF  = 128,
  parameter int NRD = 4,
  localparam int AW = $clog2(NF)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_we,
  input  logic [AW-1:0]           host_waddr,
  input  logic [FW-1:0]           host_wdata,
  input  logic                    seq_we,
  input  logic [AW-1:0]           seq_waddr,
  input  logic [FW-1:0]           seq_wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][FW-1:0]  rdata
);
  logic [FW-1:0] mem_q [NF];
  logic [FW-1:0] mem_n [NF];

  always_comb begin
    for (int f = 0; f < NF; f++) mem_n[f] = mem_q[f];
    if (seq_we)       mem_n[seq_waddr]  = seq_wdata;
    else if (host_we) mem_n[host_waddr] = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NF; f++) mem_q[f] <= '0;
    end else begin
      for (int f = 0; f < NF; f++) mem_q[f] <= mem_n[f];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem_q[raddr[r]];
  end

  // R12
  host_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !seq_we) |=> (mem_q[$past(host_waddr)] == $past(host_wdata)));
endmodule

// File: rtl/cr_elem_unit.sv
module cr_elem_unit
  import cr_seq_pkg::*;
(
  input  logic [FW-1:0] a_fld,
  input  logic [FW-1:0] b_fld,
  input  logic [FW-1:0] t_fld,
  input  logic [3:0]    lut,
  input  logic          wide,
  input  logic [1:0]    a_sel,
  input  logic [1:0]    b_sel,
  input  logic [1:0]    t_sel,
  input  logic [1:0]    test_sel,
  input  logic          pred_bit,
  input  logic          dz,
  input  logic          sz,
  input  logic          snz,
  input  logic          ffirst,
  input  logic          inv,
  input  logic          vli,
  output logic          we,
  output logic [FW-1:0] wdata,
  output logic          fail
);
  logic [FW-1:0] wide_res;
  logic          narrow_res;
  logic [FW-1:0] new_fld;
  logic [FW-1:0] zero_fld;
  logic          test_val;
  logic          test_en;

  for (genvar k = 0; k < FW; k++) begin : g_lane
    assign wide_res[k] = lut[{a_fld[k], b_fld[k]}];
  end

  assign narrow_res = lut[{a_fld[a_sel], b_fld[b_sel]}];

  always_comb begin
    new_fld  = t_fld;
    zero_fld = t_fld;
    if (wide) begin
      new_fld  = wide_res;
      zero_fld = '0;
    end else begin
      new_fld[t_sel]  = narrow_res;
      zero_fld[t_sel] = 1'b0;
    end
  end

  assign test_val = pred_bit ? (wide ? wide_res[test_sel] : narrow_res) : snz;
  assign test_en  = ffirst & (pred_bit | sz);
  assign fail     = test_en & (test_val == inv);
  assign we       = (pred_bit | dz) & ~(fail & ~vli);
  assign wdata    = pred_bit ? new_fld : zero_fld;
endmodule

// File: rtl/cr_seq_ctrl.sv
module cr_seq_ctrl #(
  parameter int MAXVL = 64,
  localparam int IW = $clog2(MAXVL),
  localparam int VW = $clog2(MAXVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] vl_in,
  input  logic          rg_in,
  input  logic          vli,
  input  logic          elem_fail,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          done,
  output logic [VW-1:0] vl_out
);
  logic          busy_q, busy_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [IW-1:0] cnt_q, cnt_n;
  logic [VW-1:0] vl_q, vl_n;
  logic          rg_q, rg_n;
  logic          done_q, done_n;
  logic [VW-1:0] vlo_q, vlo_n;
  logic [VW-1:0] vl_eff;
  logic          last;

  assign vl_eff = (vl_in > VW'(MAXVL)) ? VW'(MAXVL) : vl_in;
  assign last   = (VW'(cnt_q) + VW'(1)) == vl_q;

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    cnt_n  = cnt_q;
    vl_n   = vl_q;
    rg_n   = rg_q;
    done_n = 1'b0;
    vlo_n  = vlo_q;
    if (!busy_q) begin
      if (start) begin
        vl_n  = vl_eff;
        rg_n  = rg_in;
        cnt_n = '0;
        if (vl_eff == '0) begin
          done_n = 1'b1;
          vlo_n  = '0;
        end else begin
          busy_n = 1'b1;
          idx_n  = rg_in ? IW'(vl_eff - VW'(1)) : '0;
        end
      end
    end else if (elem_fail) begin
      busy_n = 1'b0;
      done_n = 1'b1;
      vlo_n  = vli ? VW'(idx_q) + VW'(1) : VW'(idx_q);
    end else if (last) begin
      busy_n = 1'b0;
      done_n = 1'b1;
      vlo_n  = vl_q;
    end else begin
      cnt_n = cnt_q + IW'(1);
      idx_n = rg_q ? idx_q - IW'(1) : idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      vl_q   <= '0;
      rg_q   <= 1'b0;
      done_q <= 1'b0;
      vlo_q  <= '0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
      cnt_q  <= cnt_n;
      vl_q   <= vl_n;
      rg_q   <= rg_n;
      done_q <= done_n;
      vlo_q  <= vlo_n;
    end
  end

  assign busy   = busy_q;
  assign idx    = idx_q;
  assign done   = done_q;
  assign vl_out = vlo_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R11
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (vlo_q <= vl_q));
  // R2
  fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rg_q) |=> (!busy_q || idx_q == $past(idx_q) + IW'(1)));
  // R4
  rev_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rg_q) |=> (!busy_q || idx_q == $past(idx_q) - IW'(1)));
endmodule

// File: rtl/cr_vec_seq.sv
module cr_vec_seq
  import cr_seq_pkg::*;
#(
  parameter int NFIELD = 128,
  parameter int MAXVL  = 64,
  localparam int AW = $clog2(NFIELD),
  localparam int IW = $clog2(MAXVL),
  localparam int VW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [6:0]       mode_word,
  input  logic [3:0]       op_lut,
  input  logic             field_wide,
  input  logic             a_is_vec,
  input  logic             b_is_vec,
  input  logic [AW-1:0]    a_base,
  input  logic [1:0]       a_sel,
  input  logic [AW-1:0]    b_base,
  input  logic [1:0]       b_sel,
  input  logic [AW-1:0]    t_base,
  input  logic [1:0]       t_sel,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic [VW-1:0]    vl_in,
  output logic             busy,
  output logic             done,
  output logic [VW-1:0]    vl_out,
  input  logic             host_we,
  input  logic [AW-1:0]    host_waddr,
  input  logic [FW-1:0]    host_wdata,
  input  logic [AW-1:0]    host_raddr,
  output logic [FW-1:0]    host_rdata
);
  typedef struct packed {
    mode_t            mode;
    logic [3:0]       lut;
    logic             wide;
    logic             va;
    logic             vb;
    logic [AW-1:0]    ab;
    logic [1:0]       as;
    logic [AW-1:0]    bb;
    logic [1:0]       bs;
    logic [AW-1:0]    tb;
    logic [1:0]       ts;
    logic [MAXVL-1:0] pred;
  } cfg_t;

  cfg_t cfg_q, cfg_n;
  logic cfg_load;

  assign cfg_load = start & ~busy;

  always_comb begin
    cfg_n = cfg_q;
    if (cfg_load)
      cfg_n = '{mode: mode_t'(mode_word), lut: op_lut, wide: field_wide,
                va: a_is_vec, vb: b_is_vec, ab: a_base, as: a_sel,
                bb: b_base, bs: b_sel, tb: t_base, ts: t_sel, pred: pred_mask};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  // mode decode
  logic ffirst, reduce, vli, inv, dz, sz, rg_start;
  assign ffirst   = cfg_q.mode.sel[0];
  assign reduce   = cfg_q.mode.sel == SEL_REDUCE;
  assign vli      = ffirst & cfg_q.mode.sel[1];
  assign inv      = ffirst & cfg_q.mode.rgi;
  assign dz       = (ffirst & cfg_q.wide) ? cfg_q.mode.zz : cfg_q.mode.lo[1];
  assign sz       = (ffirst & cfg_q.wide) ? cfg_q.mode.zz : cfg_q.mode.lo[0];
  assign rg_start = ~mode_word[3] & mode_word[2];

  logic [IW-1:0] idx;
  logic          elem_fail, elem_we, seq_we;
  logic [FW-1:0] elem_wdata;
  logic [AW-1:0] a_addr, b_addr, t_addr;
  logic [3:0][AW-1:0] raddr;
  logic [3:0][FW-1:0] rdata;

  assign a_addr = cfg_q.ab + (cfg_q.va ? AW'(idx) : '0);
  assign b_addr = cfg_q.bb + (cfg_q.vb ? AW'(idx) : '0);
  assign t_addr = cfg_q.tb + (reduce ? '0 : AW'(idx));
  assign raddr  = {host_raddr, t_addr, b_addr, a_addr};
  assign host_rdata = rdata[3];
  assign seq_we = busy & elem_we;

  cr_seq_ctrl #(.MAXVL(MAXVL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .rg_in(rg_start),
    .vli(vli), .elem_fail(elem_fail), .busy(busy), .idx(idx), .done(done),
    .vl_out(vl_out)
  );

  cr_elem_unit u_elem (
    .a_fld(rdata[0]), .b_fld(rdata[1]), .t_fld(rdata[2]), .lut(cfg_q.lut),
    .wide(cfg_q.wide), .a_sel(cfg_q.as), .b_sel(cfg_q.bs), .t_sel(cfg_q.ts),
    .test_sel(cfg_q.mode.lo), .pred_bit(cfg_q.pred[idx]), .dz(dz), .sz(sz),
    .snz(cfg_q.mode.snz), .ffirst(ffirst & busy), .inv(inv), .vli(vli),
    .we(elem_we), .wdata(elem_wdata), .fail(elem_fail)
  );

  cr_field_file #(.NF(NFIELD), .NRD(4)) u_file (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .seq_we(seq_we), .seq_waddr(t_addr),
    .seq_wdata(elem_wdata), .raddr(raddr), .rdata(rdata)
  );

  // R8
  trunc_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && elem_fail && !vli) |-> !seq_we);
  // R5
  pred_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_q.pred[idx] && !dz) |-> !seq_we);
  // R11
  fail_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && elem_fail) |=> (done && !busy));
endmodule

// File: tb/cr_vec_seq_bench.sv
module cr_vec_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 128;
  localparam int MV = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic start, field_wide, a_is_vec, b_is_vec, host_we, busy, done;
  logic [6:0] mode_word, a_base, b_base, t_base, vl_in, vl_out, host_waddr, host_raddr;
  logic [3:0] op_lut, host_wdata, host_rdata;
  logic [1:0] a_sel, b_sel, t_sel;
  logic [MV-1:0] pred_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [3:0] refm [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  cr_vec_seq u_cr_vec_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word), .op_lut(op_lut),
    .field_wide(field_wide), .a_is_vec(a_is_vec), .b_is_vec(b_is_vec),
    .a_base(a_base), .a_sel(a_sel), .b_base(b_base), .b_sel(b_sel),
    .t_base(t_base), .t_sel(t_sel), .pred_mask(pred_mask), .vl_in(vl_in),
    .busy(busy), .done(done), .vl_out(vl_out), .host_we(host_we),
    .host_waddr(host_waddr), .host_wdata(host_wdata), .host_raddr(host_raddr),
    .host_rdata(host_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input int s, input int f);
    logic [31:0] x;
    x = 32'(s) * 32'h9E3779B1 ^ (32'(f) * 32'h85EBCA77);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    return x ^ (x >> 12);
  endfunction

  task automatic run_case(input string tag, input logic [6:0] mw, input logic [3:0] lut,
                          input bit wide, input bit va, input bit vb,
                          input int ba, input int as, input int bb, input int bs,
                          input int bt, input int ts, input logic [MV-1:0] pred,
                          input int vl, input int seed);
    bit ff, red, vli, rg, inv, dz, sz, snz, fail, p, tv, nr;
    int vle, exp_vl, exp_cyc, cyc, e, bad_f, bad_a, bad_e;
    logic [3:0] af, bf, tf, wr, nf, zf;
    // load the field file through the host port
    for (int f = 0; f < NF; f++) begin
      @(negedge clk);
      host_we = 1'b1; host_waddr = 7'(f); host_wdata = mix(seed, f)[7:4];
      refm[f] = mix(seed, f)[7:4];
    end
    @(negedge clk);
    host_we = 1'b0;
    host_raddr = 7'(NF - 1);
    #1;
    chk({tag, " R12 host readback"}, int'(host_rdata), int'(refm[NF-1]));
    // expected outcome
    ff = mw[3]; red = (mw[4:3] == 2'b10); vli = ff & mw[4];
    rg = !ff & mw[2]; inv = ff & mw[2];
    dz = (wide && ff) ? mw[6] : mw[1];
    sz = (wide && ff) ? mw[6] : mw[0];
    snz = mw[5];
    vle = (vl > MV) ? MV : vl;
    exp_vl = vle; exp_cyc = vle;
    for (int c = 0; c < vle; c++) begin
      e  = rg ? vle - 1 - c : c;
      af = refm[(ba + (va ? e : 0)) % NF];
      bf = refm[(bb + (vb ? e : 0)) % NF];
      tf = refm[(bt + (red ? 0 : e)) % NF];
      for (int k = 0; k < 4; k++) wr[k] = lut[2*af[k] + bf[k]];
      nr = lut[2*af[as] + bf[bs]];
      nf = tf; zf = tf;
      if (wide) begin nf = wr; zf = 4'b0; end
      else begin nf[ts] = nr; zf[ts] = 1'b0; end
      p  = pred[e];
      tv = p ? (wide ? wr[mw[1:0]] : nr) : snz;
      fail = ff && (p || sz) && (tv == inv);
      if ((p || dz) && !(fail && !vli)) refm[(bt + (red ? 0 : e)) % NF] = p ? nf : zf;
      if (fail) begin
        exp_vl = vli ? e + 1 : e;
        exp_cyc = c + 1;
        break;
      end
    end
    // run
    @(negedge clk);
    mode_word = mw; op_lut = lut; field_wide = wide; a_is_vec = va; b_is_vec = vb;
    a_base = 7'(ba); a_sel = 2'(as); b_base = 7'(bb); b_sel = 2'(bs);
    t_base = 7'(bt); t_sel = 2'(ts); pred_mask = pred; vl_in = 7'(vl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R11 done latency"}, cyc, exp_cyc);
    chk({tag, " vl_out"}, int'(vl_out), exp_vl);
    bad_f = -1; bad_a = 0; bad_e = 0;
    for (int f = 0; f < NF; f++) begin
      host_raddr = 7'(f);
      #1;
      if (bad_f < 0 && host_rdata !== refm[f]) begin
        bad_f = f; bad_a = int'(host_rdata); bad_e = int'(refm[f]);
      end
    end
    if (bad_f >= 0) $display("field %0d differs", bad_f);
    chk({tag, " field file"}, bad_a, bad_e);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] luts [4];
    int vls [4];
    logic [MV-1:0] prnd;
    int sd;
    luts[0] = 4'b1000; luts[1] = 4'b1110; luts[2] = 4'b0110; luts[3] = 4'b0001;
    vls[0] = 1; vls[1] = 13; vls[2] = 64; vls[3] = 100;
    rst_n = 1'b0; start = 1'b0; host_we = 1'b0; host_waddr = '0; host_wdata = '0;
    host_raddr = '0; mode_word = '0; op_lut = '0; field_wide = 1'b0; a_is_vec = 1'b0;
    b_is_vec = 1'b0; a_base = '0; b_base = '0; t_base = '0; a_sel = '0; b_sel = '0;
    t_sel = '0; pred_mask = '0; vl_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 vl_out after reset", int'(vl_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case("R11 zero length", 7'b0000000, 4'b1000, 0, 1, 1, 10, 0, 40, 2, 80, 1, '1, 0, 7);
    for (int li = 0; li < 4; li++)
      for (int sc = 0; sc < 11; sc++)
        for (int vi = 0; vi < 4; vi++) begin
          sd = li * 100 + sc * 10 + vi + 1;
          prnd = {mix(sd, 900), mix(sd, 901)};
          case (sc)
            0:  run_case("R2 plain narrow", 7'b0000000, luts[li], 0, 1, 1, 10, 0, 40, 2, 80, 1, '1, vls[vi], sd);
            1:  run_case("R3 plain wide", 7'b0000000, luts[li], 1, 1, 1, 8, 0, 50, 0, 90, 0, '1, vls[vi], sd);
            2:  run_case("R4 reverse cascade", 7'b0000100, luts[li], 0, 1, 1, 20, 2, 21, 2, 20, 2, '1, vls[vi], sd);
            3:  run_case("R5 predicate skip", 7'b0000000, luts[li], 0, 1, 1, 10, 1, 40, 3, 80, 0, prnd, vls[vi], sd);
            4:  run_case("R5 predicate zero wide", 7'b0000110, luts[li], 1, 1, 1, 12, 0, 44, 0, 76, 0, prnd, vls[vi], sd);
            5:  run_case("R6 reduce", {6'b000100 | 6'(li[0] << 1), 1'b0} >> 1 | 7'(li[0] << 2) | 7'b0010000, luts[li], 0, 0, 1, 5, 3, 30, 1, 5, 3, '1, vls[vi], sd);
            6:  run_case("R7 early exit inclusive", 7'b0011000, luts[li], 0, 1, 1, 10, 0, 40, 2, 80, 1, '1, vls[vi], sd);
            7:  run_case("R8 early exit exclusive", 7'b0001100, luts[li], 0, 1, 1, 10, 0, 40, 2, 80, 1, '1, vls[vi], sd);
            8:  run_case("R9 wide test select", 7'b0011010, luts[li], 1, 1, 1, 8, 0, 50, 0, 90, 0, '1, vls[vi], sd);
            9:  run_case("R10 masked test value", {1'b0, li[0], 5'b01001}, luts[li], 0, 1, 1, 10, 0, 40, 2, 80, 1, prnd, vls[vi], sd);
            default: run_case("R9 R10 wide zz", 7'b1101101, luts[li], 1, 1, 1, 9, 0, 51, 0, 91, 0, prnd, vls[vi], sd);
          endcase
        end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule